// File: doc/BRIEF.md
# Auto-Negotiation Priority Resolver

This block settles the operating mode of an Ethernet link once the exchange of ability words with the far end has finished. It takes the local advertisement word and the partner ability word, both 16 bits. It also takes a one-cycle strobe that says negotiation has completed. On that strobe it keeps only the technologies that both ends offer and picks the best one by a fixed ranking. It then registers the chosen mode with its speed and duplex, a valid flag, and the partner's next-page bit.

When the selector fields of the two words disagree with the single accepted value, or the two ends share no technology, the block raises an error flag in place of a result. A result or an error is held until a restart strobe clears it. Further completion strobes are ignored while something is held, and so is any change on the ability words. The exchange that fills the ability words and all next-page handling belong to other blocks.

Top module: `anr_resolver`

## Requirements
- R1: After reset, valid_o, error_o, mode_o, speed100_o, full_duplex_o and partner_np_o are all 0.
- R2: The common set is the bitwise AND of the two words. The highest-ranked member wins, ranked from top to bottom: 100BASE-TX full duplex, 100BASE-T4, 100BASE-TX half duplex, 10BASE-T full duplex, 10BASE-T half duplex.
- R3: Ability bit positions in both words are: bit 8 TX full duplex, bit 9 T4, bit 7 TX half duplex, bit 6 10 full duplex, bit 5 10 half duplex. mode_o is coded 5 = TX full, 4 = T4, 3 = TX half, 2 = 10 full, 1 = 10 half, 0 = none.
- R4: speed100_o is 1 for codes 5, 4 and 3. full_duplex_o is 1 for codes 5 and 2 only, so T4 reports half duplex.
- R5: If bits 4:0 of either word differ from 00001, a completion strobe sets error_o=1 with valid_o=0 and mode_o=0, whatever the common set holds.
- R6: If the selectors match but the common set is empty, a completion strobe sets error_o=1 with valid_o=0 and mode_o=0.
- R7: Outputs change only on the clock edge after done_i or restart_i. While valid_o or error_o is 1, done_i and any change of the ability words have no effect on the outputs.
- R8: restart_i clears every output on the next edge and takes precedence over a done_i in the same cycle.
- R9: A completion strobe that is accepted captures bit 15 of the partner word on partner_np_o, in both the result case and the error case.
- R10: A result appears on the outputs in the cycle right after the cycle in which done_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Clears the held result |
| done_i | input | 1 | Negotiation-complete strobe |
| local_word_i | input | 16 | Local advertisement word |
| partner_word_i | input | 16 | Partner ability word |
| valid_o | output | 1 | A common mode was resolved |
| error_o | output | 1 | Selector mismatch or no common mode |
| mode_o | output | 3 | Resolved mode code |
| speed100_o | output | 1 | Resolved speed is 100 Mb/s |
| full_duplex_o | output | 1 | Resolved mode is full duplex |
| partner_np_o | output | 1 | Partner next-page bit |

## Verification
The hardest case to reach from the ports is a held result meeting new activity. A second completion strobe arrives together with ability words that would resolve differently, and the bench must show the held values survive it. The bench gets there by first resolving one pair of words. It then changes both words, fires done_i again without a restart, and finally issues restart_i and done_i in the same cycle. In each step the scoreboard expects unchanged or cleared outputs.

// File: rtl/anr_pkg.sv
package anr_pkg;
    localparam int WORD_W  = 16;
    localparam int SEL_W   = 5;
    localparam int LEVELS  = 5;
    localparam int CODE_W  = $clog2(LEVELS + 1);
    localparam int NP_BIT  = 15;

    // Ability bit for each rank, index 0 is the highest rank
    localparam int RANK_BIT [LEVELS] = '{8, 9, 7, 6, 5};

    typedef enum logic [CODE_W-1:0] {
        MODE_NONE = 3'd0,
        MODE_10HD = 3'd1,
        MODE_10FD = 3'd2,
        MODE_TXHD = 3'd3,
        MODE_T4   = 3'd4,
        MODE_TXFD = 3'd5
    } mode_t;

    typedef struct packed {
        logic  valid;
        logic  error;
        mode_t mode;
        logic  fast;
        logic  full;
        logic  np;
    } res_t;
endpackage

// File: rtl/anr_common.sv
module anr_common
    import anr_pkg::*;
#(
    parameter int W        = WORD_W,
    parameter int SW       = SEL_W,
    parameter int N        = LEVELS,
    parameter logic [SW-1:0] SEL_OK = 1
) (
    input  logic [W-1:0] local_i,
    input  logic [W-1:0] partner_i,
    output logic         sel_match_o,
    output logic [N-1:0] ranked_o
);
    logic [W-1:0] both;

    assign both        = local_i & partner_i;
    assign sel_match_o = (local_i[SW-1:0] == SEL_OK) && (partner_i[SW-1:0] == SEL_OK);

    for (genvar r = 0; r < N; r++) begin : g_rank
        assign ranked_o[r] = both[RANK_BIT[r]];
    end
endmodule

// File: rtl/anr_pick.sv
module anr_pick
    import anr_pkg::*;
#(
    parameter int N  = LEVELS,
    parameter int CW = CODE_W
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [CW-1:0] code_o
);
    logic [N-1:0] blocked;
    logic [N-1:0] grant;

    for (genvar r = 0; r < N; r++) begin : g_chain
        if (r == 0) begin : g_top
            assign blocked[r] = 1'b0;
        end else begin : g_rest
            assign blocked[r] = blocked[r-1] | req_i[r-1];
        end
        assign grant[r] = req_i[r] & ~blocked[r];
    end

    assign any_o = |req_i;

    always_comb begin
        code_o = '0;
        for (int r = 0; r < N; r++) begin
            if (grant[r]) code_o = CW'(N - r);
        end
    end
endmodule

// File: rtl/anr_decode.sv
module anr_decode
    import anr_pkg::*;
(
    input  mode_t mode_i,
    output logic  fast_o,
    output logic  full_o
);
    always_comb begin
        fast_o = 1'b0;
        full_o = 1'b0;
        unique case (mode_i)
            MODE_TXFD: begin fast_o = 1'b1; full_o = 1'b1; end
            MODE_T4,
            MODE_TXHD: fast_o = 1'b1;
            MODE_10FD: full_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/anr_resolver.sv
module anr_resolver
    import anr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              restart_i,
    input  logic              done_i,
    input  logic [WORD_W-1:0] local_word_i,
    input  logic [WORD_W-1:0] partner_word_i,
    output logic              valid_o,
    output logic              error_o,
    output logic [CODE_W-1:0] mode_o,
    output logic              speed100_o,
    output logic              full_duplex_o,
    output logic              partner_np_o
);
    logic              sel_match;
    logic [LEVELS-1:0] ranked;
    logic              any_common;
    logic [CODE_W-1:0] pick_code;
    mode_t             pick_mode;
    logic              pick_fast;
    logic              pick_full;
    res_t              res_d, res_q;

    anr_common u_common (
        .local_i     (local_word_i),
        .partner_i   (partner_word_i),
        .sel_match_o (sel_match),
        .ranked_o    (ranked)
    );

    anr_pick u_pick (
        .req_i  (ranked),
        .any_o  (any_common),
        .code_o (pick_code)
    );

    assign pick_mode = mode_t'(pick_code);

    anr_decode u_decode (
        .mode_i (pick_mode),
        .fast_o (pick_fast),
        .full_o (pick_full)
    );

    always_comb begin
        res_d = res_q;
        if (restart_i) begin
            res_d = '0;
        end else if (done_i && !(res_q.valid || res_q.error)) begin
            res_d.np = partner_word_i[NP_BIT];
            if (sel_match && any_common) begin
                res_d.valid = 1'b1;
                res_d.error = 1'b0;
                res_d.mode  = pick_mode;
                res_d.fast  = pick_fast;
                res_d.full  = pick_full;
            end else begin
                res_d.valid = 1'b0;
                res_d.error = 1'b1;
                res_d.mode  = MODE_NONE;
                res_d.fast  = 1'b0;
                res_d.full  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign valid_o       = res_q.valid;
    assign error_o       = res_q.error;
    assign mode_o        = res_q.mode;
    assign speed100_o    = res_q.fast;
    assign full_duplex_o = res_q.full;
    assign partner_np_o  = res_q.np;
endmodule

// File: rtl/anr_resolver_chk.sv
module anr_resolver_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       restart_i,
    input logic       done_i,
    input logic       valid_o,
    input logic       error_o,
    input logic [2:0] mode_o,
    input logic       speed100_o,
    input logic       full_duplex_o,
    input logic       partner_np_o
);
    assert_restart_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (!valid_o && !error_o && mode_o == 3'd0 && !partner_np_o));

    assert_valid_error_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_o && error_o));

    assert_error_no_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_o |-> (mode_o == 3'd0 && !speed100_o && !full_duplex_o));

    assert_valid_has_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (mode_o != 3'd0 && mode_o <= 3'd5));

    assert_idle_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!done_i && !restart_i) |=> ($stable(mode_o) && $stable(valid_o) && $stable(error_o)
                                     && $stable(partner_np_o)));

    assert_held_ignores_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((valid_o || error_o) && !restart_i) |=> ($stable(mode_o) && $stable(valid_o)
                                                  && $stable(error_o)));

    assert_t4_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd4) |-> (speed100_o && !full_duplex_o));
endmodule

bind anr_resolver anr_resolver_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .restart_i     (restart_i),
    .done_i        (done_i),
    .valid_o       (valid_o),
    .error_o       (error_o),
    .mode_o        (mode_o),
    .speed100_o    (speed100_o),
    .full_duplex_o (full_duplex_o),
    .partner_np_o  (partner_np_o)
);

// File: tb/sim_anr_resolver.sv
`timescale 1ns/1ps
module sim_anr_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        done = 1'b0;
    logic [15:0] lw = '0;
    logic [15:0] pw = '0;
    logic        valid, error, fast, full, np;
    logic [2:0]  mode;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    typedef struct {
        logic       valid;
        logic       error;
        logic [2:0] mode;
        logic       fast;
        logic       full;
        logic       np;
        string      tag;
    } exp_t;

    exp_t model;
    exp_t q[$];

    always #2.5 clk = ~clk;

    anr_resolver u0 (
        .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .done_i(done),
        .local_word_i(lw), .partner_word_i(pw),
        .valid_o(valid), .error_o(error), .mode_o(mode),
        .speed100_o(fast), .full_duplex_o(full), .partner_np_o(np)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (valid !== e.valid || error !== e.error || mode !== e.mode ||
            fast !== e.fast || full !== e.full || np !== e.np) begin
            fails++;
            $display("FAIL %s: got v=%0b e=%0b m=%0d f=%0b fd=%0b np=%0b exp v=%0b e=%0b m=%0d f=%0b fd=%0b np=%0b",
                     e.tag, valid, error, mode, fast, full, np,
                     e.valid, e.error, e.mode, e.fast, e.full, e.np);
        end
    endtask

    // Model of the requirements: bits 8,9,7,6,5 ranked; selector 00001
    function automatic exp_t resolve(input logic [15:0] a, input logic [15:0] b, input string tag);
        exp_t r;
        logic [15:0] c;
        c = a & b;
        r.tag = tag; r.np = b[15];
        r.valid = 1'b1; r.error = 1'b0; r.fast = 1'b0; r.full = 1'b0;
        if (a[4:0] != 5'd1 || b[4:0] != 5'd1) begin
            r.valid = 1'b0; r.error = 1'b1; r.mode = 3'd0;
        end else if (c[8]) begin r.mode = 3'd5; r.fast = 1'b1; r.full = 1'b1; end
        else if (c[9]) begin r.mode = 3'd4; r.fast = 1'b1; end
        else if (c[7]) begin r.mode = 3'd3; r.fast = 1'b1; end
        else if (c[6]) begin r.mode = 3'd2; r.full = 1'b1; end
        else if (c[5]) begin r.mode = 3'd1; end
        else begin r.valid = 1'b0; r.error = 1'b1; r.mode = 3'd0; end
        return r;
    endfunction

    task automatic step(input logic rs, input logic dn, input logic [15:0] a,
                        input logic [15:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        restart = rs; done = dn; lw = a; pw = b;
        if (rs) begin
            e = '{valid: 1'b0, error: 1'b0, mode: 3'd0, fast: 1'b0, full: 1'b0, np: 1'b0, tag: tag};
            model = e;
        end else if (dn && !(model.valid || model.error)) begin
            model = resolve(a, b, tag);
        end
        e = model; e.tag = tag;
        if (rs || dn) q.push_back(e);
        @(negedge clk);
        restart = 1'b0; done = 1'b0;
    endtask

    // Monitor: pops one expected item for each edge that saw a strobe (R10)
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && (done || restart)) begin
                #1;
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R10: result with no expected item, got m=%0d exp none", mode);
                end else begin
                    checks--;
                    compare(q.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: run did not end, got hang exp completion");
        finish_run();
    end

    localparam logic [15:0] SEL = 16'h0001;
    localparam logic [15:0] ALL = 16'h03E1;

    initial begin
        exp_t h;
        model = '{valid: 1'b0, error: 1'b0, mode: 3'd0, fast: 1'b0, full: 1'b0, np: 1'b0, tag: "R1"};
        repeat (3) @(negedge clk);
        model.tag = "R1 reset state";
        compare(model);
        rst_n = 1'b1;
        @(negedge clk);

        step(0, 1, ALL, ALL, "R2 all common picks TX full");
        step(1, 0, ALL, ALL, "R8 restart clears");
        step(0, 1, SEL | 16'h0280, SEL | 16'h0280, "R2 T4 over TX half");
        step(1, 0, '0, '0, "R8 restart");
        step(0, 1, SEL | 16'h0100, SEL | 16'h0080 | 16'h0100 & 16'h0000, "R6 TXFD vs TX empty");
        step(1, 0, '0, '0, "R8 restart");
        step(0, 1, ALL, SEL | 16'h0080, "R3 TX half bit 7");
        step(1, 0, '0, '0, "R8 restart");
        step(0, 1, ALL, SEL | 16'h0060, "R4 10 full duplex");
        step(1, 0, '0, '0, "R8 restart");
        step(0, 1, SEL | 16'h0020, ALL, "R3 10 half bit 5");
        step(1, 0, '0, '0, "R8 restart");
        step(0, 1, ALL, (ALL & ~16'h001F) | 16'h0002, "R5 partner selector bad");
        step(1, 0, '0, '0, "R8 restart");
        step(0, 1, (ALL & ~16'h001F) | 16'h0011, ALL, "R5 local selector bad");
        step(1, 0, '0, '0, "R8 restart");
        step(0, 1, SEL | 16'h0040, SEL | 16'h0020, "R6 no common mode");
        step(1, 0, '0, '0, "R8 restart");
        step(0, 1, ALL, ALL | 16'h8000, "R9 next page captured");
        step(1, 0, '0, '0, "R8 restart");
        step(0, 1, SEL | 16'h0040, SEL | 16'h8020, "R9 next page on error");
        step(1, 0, '0, '0, "R8 restart");

        // R7: hold against word changes and a second done
        step(0, 1, SEL | 16'h0020, SEL | 16'h0020, "R7 first resolve 10 half");
        @(negedge clk);
        lw = ALL; pw = ALL | 16'h8000;
        repeat (3) @(negedge clk);
        h = model; h.tag = "R7 word change ignored";
        compare(h);
        step(0, 1, ALL, ALL | 16'h8000, "R7 done while held ignored");
        step(1, 1, ALL, ALL, "R8 restart beats done");
        step(0, 1, SEL | 16'h0300, SEL | 16'h0200, "R4 T4 is half duplex");
        step(1, 0, '0, '0, "R8 final restart");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10: %0d results missing, exp 0", q.size());
        end
        finish_run();
    end
endmodule